// File: doc/BRIEF.md
# External Interrupt Status and Control Register

This block is one 8-bit register on the CPU's peripheral bus. It holds the interrupt state for two event sources: an external interrupt pin and a port-level interrupt source. Each source has a sticky flag, which a one-cycle detection pulse sets. Each flag has its own enable bit. An enabled flag that is pending drives a single registered interrupt request to the core. Software clears both pending flags at once by writing 1 to an acknowledge bit.

The acknowledge bit always reads back as 0. Software can therefore use read-modify-write bit instructions on the register without acknowledging by accident. When the core enters STOP or WAIT, the block forces the pin enable to 1, so that the external pin can always wake the device. Edge or level detection on the pins, the core's global interrupt mask and vector fetch belong to other blocks. All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `xirq_ctl_reg`

## Requirements
- R1: The register decodes only at address 0x1F. A read at any other address returns 0x00. A write at any other address changes no state.
- R2: The read layout is: bit 7 = pin enable, bit 5 = port enable, bit 3 = pin flag, bit 1 = port flag. Bits 6, 4, 2 and 0 always read 0.
- R3: After reset the register reads 0x80 (only the pin enable is set) and the interrupt request is 0.
- R4: A write to 0x1F loads the pin enable from data bit 7 and the port enable from data bit 5. Data bits 3 and 1 never change the flags.
- R5: A one-cycle pulse on `pin_evt` or `port_evt` sets the matching flag at the next clock edge. The flag stays set until it is acknowledged.
- R6: A write to 0x1F with data bit 0 = 1 clears both flags. A write with data bit 0 = 0 leaves the flags unchanged.
- R7: If an event pulse and an acknowledge happen in the same cycle, that source's flag ends up set.
- R8: `irq_req` equals (pin flag AND pin enable) OR (port flag AND port enable), as that value stood one clock edge earlier.
- R9: While `core_stop` or `core_wait` is high, the pin enable is set to 1 at the clock edge. This override wins over a simultaneous write of 0 to bit 7.
- R10: Writing back to 0x1F the value just read from it leaves every enable and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0x00 when the register is not selected) |
| pin_evt | input | 1 | One-cycle pulse: event detected on the external pin |
| port_evt | input | 1 | One-cycle pulse: event detected on the port source |
| core_stop | input | 1 | Core is executing STOP |
| core_wait | input | 1 | Core is executing WAIT |
| irq_req | output | 1 | Combined interrupt request to the core |

## Verification
A flag or enable that holds the wrong value shows up in two places. It appears on `bus_rdata` at the first read of 0x1F after the fault. If the wrong value changes the gated OR, it also appears on `irq_req` one clock edge later. A missed set or clear therefore becomes visible within two cycles, as long as the bench reads the register every step. The bench's reference model checks `irq_req` on every clock and checks the read value whenever a read is issued.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int DATA_W        = 8;
  localparam int NUM_SRC       = 2;
  localparam int SRC_PIN       = 0;
  localparam int SRC_PORT      = 1;
  localparam int BIT_PIN_EN    = 7;
  localparam int BIT_PORT_EN   = 5;
  localparam int BIT_PIN_FLG   = 3;
  localparam int BIT_PORT_FLG  = 1;
  localparam int BIT_ACK       = 0;

  typedef struct packed {
    logic               en_load;
    logic [NUM_SRC-1:0] en_val;
    logic               ack;
  } xirq_wcmd_t;

  function automatic int en_bit(input int src);
    return (src == SRC_PIN) ? BIT_PIN_EN : BIT_PORT_EN;
  endfunction

  function automatic int flg_bit(input int src);
    return (src == SRC_PIN) ? BIT_PIN_FLG : BIT_PORT_FLG;
  endfunction
endpackage

// File: rtl/xirq_bus_dec.sv
module xirq_bus_dec
  import xirq_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1F
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic [NUM_SRC-1:0] flg_q,
  output xirq_wcmd_t        wcmd,
  output logic [DATA_W-1:0] bus_rdata
);
  logic hit;
  logic [DATA_W-1:0] img;
  logic unused_wbits;

  assign hit = (bus_addr == REG_ADDR);

  always_comb begin
    img = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      img[en_bit(s)]  = en_q[s];
      img[flg_bit(s)] = flg_q[s];
    end
  end

  assign bus_rdata = (hit && bus_rd) ? img : '0;

  always_comb begin
    wcmd.en_load = hit && bus_wr;
    wcmd.ack     = hit && bus_wr && bus_wdata[BIT_ACK];
    for (int s = 0; s < NUM_SRC; s++)
      wcmd.en_val[s] = bus_wdata[en_bit(s)];
  end

  assign unused_wbits = ^{bus_wdata[6], bus_wdata[4:1]};
endmodule

// File: rtl/xirq_src_slice.sv
module xirq_src_slice #(
  parameter logic EN_RST     = 1'b0,
  parameter bit   WAKE_FORCE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_load,
  input  logic en_val,
  input  logic ack,
  input  logic evt,
  input  logic wake,
  output logic en_q,
  output logic flg_q,
  output logic req
);
  logic en_d;
  logic unused_wake;

  generate
    if (WAKE_FORCE) begin : g_wake
      assign en_d = wake ? 1'b1 : (en_load ? en_val : en_q);
      assign unused_wake = 1'b0;
    end else begin : g_nowake
      assign en_d = en_load ? en_val : en_q;
      assign unused_wake = wake;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= EN_RST;
      flg_q <= 1'b0;
    end else begin
      en_q <= en_d;
      if (evt)      flg_q <= 1'b1;
      else if (ack) flg_q <= 1'b0;
    end
  end

  assign req = en_q & flg_q;

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flg_q); // R5
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ack) |=> flg_q); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt) |=> !flg_q); // R6
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !evt) |=> $stable(flg_q)); // R6
  generate
    if (WAKE_FORCE) begin : g_wake_chk
      AST_WAKE_FORCES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> en_q); // R9
    end
  endgenerate
endmodule

// File: rtl/xirq_irq_merge.sv
module xirq_irq_merge #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  output logic               irq_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= |req;
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> !irq_req); // R8
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> irq_req); // R8
endmodule

// File: rtl/xirq_ctl_reg.sv
module xirq_ctl_reg
  import xirq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              pin_evt,
  input  logic              port_evt,
  input  logic              core_stop,
  input  logic              core_wait,
  output logic              irq_req
);
  xirq_wcmd_t         wcmd;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] flg_q;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] evt;
  logic               wake;

  assign evt[SRC_PIN]  = pin_evt;
  assign evt[SRC_PORT] = port_evt;
  assign wake          = core_stop | core_wait;

  xirq_bus_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) dec_i (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .en_q     (en_q),
    .flg_q    (flg_q),
    .wcmd     (wcmd),
    .bus_rdata(bus_rdata)
  );

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      xirq_src_slice #(
        .EN_RST    (s == SRC_PIN),
        .WAKE_FORCE(s == SRC_PIN)
      ) slice_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_load(wcmd.en_load),
        .en_val (wcmd.en_val[s]),
        .ack    (wcmd.ack),
        .evt    (evt[s]),
        .wake   (wake),
        .en_q   (en_q[s]),
        .flg_q  (flg_q[s]),
        .req    (req[s])
      );
    end
  endgenerate

  xirq_irq_merge #(.NUM_SRC(NUM_SRC)) merge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .irq_req(irq_req)
  );

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[6] == 1'b0) && (bus_rdata[4] == 1'b0) && (bus_rdata[2] == 1'b0) && (bus_rdata[0] == 1'b0)); // R2
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != REG_ADDR) |-> (bus_rdata == 8'h00)); // R1
  AST_MISS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != REG_ADDR && !core_stop && !core_wait) |=> $stable(en_q)); // R1
endmodule

// File: tb/xirq_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module xirq_ctl_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       pin_evt = 1'b0, port_evt = 1'b0, core_stop = 1'b0, core_wait = 1'b0;
  logic       irq_req;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  bit m_pin_en = 1'b1, m_port_en = 1'b0, m_pin_f = 1'b0, m_port_f = 1'b0, m_irq = 1'b0;

  always #4 clk = ~clk;

  xirq_ctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_evt(pin_evt), .port_evt(port_evt),
    .core_stop(core_stop), .core_wait(core_wait), .irq_req(irq_req)
  );

  function automatic logic [7:0] model_read(input logic [7:0] a);
    if (a != 8'h1F) return 8'h00;
    return {m_pin_en, 1'b0, m_port_en, 1'b0, m_pin_f, 1'b0, m_port_f, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // One bus cycle; the reference model advances at the following rising edge.
  task automatic step(input string tag, input logic [7:0] a, input bit rd, input bit wr,
                      input logic [7:0] wd, input bit pe, input bit qe,
                      input bit stp, input bit wt);
    bit hitw, ack;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    pin_evt = pe; port_evt = qe; core_stop = stp; core_wait = wt;
    #1;
    chk("R8 irq_req", {7'b0, irq_req}, {7'b0, m_irq});
    if (rd) chk(tag, bus_rdata, model_read(a));
    @(posedge clk);
    hitw  = wr && (a == 8'h1F);
    ack   = hitw && wd[0];
    m_irq = (m_pin_f && m_pin_en) || (m_port_f && m_port_en);
    if (stp || wt)  m_pin_en = 1'b1;
    else if (hitw)  m_pin_en = wd[7];
    if (hitw)       m_port_en = wd[5];
    m_pin_f  = pe ? 1'b1 : (ack ? 1'b0 : m_pin_f);
    m_port_f = qe ? 1'b1 : (ack ? 1'b0 : m_port_f);
  endtask

  task automatic rd_reg(input string tag);
    step(tag, 8'h1F, 1, 0, 8'h00, 0, 0, 0, 0);
  endtask

  task automatic wr_reg(input logic [7:0] d);
    step("wr", 8'h1F, 0, 1, d, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] snap;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R3 reset irq", {7'b0, irq_req}, 8'h00);
    rd_reg("R3 reset read");
    #1 chk("R3 reset value", bus_rdata, 8'h80);
    step("R1 miss read", 8'h1E, 1, 0, 8'h00, 0, 0, 0, 0);
    #1 chk("R1 miss read zero", bus_rdata, 8'h00);

    wr_reg(8'hFE);                        // R4: flag bits in data do nothing
    rd_reg("R4 enables set");
    #1 chk("R2 R4 layout", bus_rdata, 8'hA0);

    step("R1 miss write", 8'h3F, 0, 1, 8'h00, 0, 0, 0, 0);
    rd_reg("R1 miss write ignored");

    step("R5 pin evt", 8'h00, 0, 0, 8'h00, 1, 0, 0, 0);
    rd_reg("R5 pin flag");
    #1 chk("R5 pin flag read", bus_rdata, 8'hA8);
    rd_reg("R8 irq up");
    chk("R8 irq asserted", {7'b0, irq_req}, 8'h01);

    wr_reg(8'h20);                        // gate pin off
    rd_reg("R8 gated flag kept");
    rd_reg("R8 gated irq low");
    chk("R8 irq gated", {7'b0, irq_req}, 8'h00);

    step("R5 port evt", 8'h00, 0, 0, 8'h00, 0, 1, 0, 0);
    rd_reg("R5 port flag");
    #1 chk("R5 both flags", bus_rdata, 8'h2A);

    // R10: read-modify-write with the value read back
    rd_reg("R10 snapshot");
    #1 snap = bus_rdata;
    wr_reg(snap | 8'h80);
    rd_reg("R10 bit-set rmw");
    #1 chk("R10 rmw no ack", bus_rdata, 8'hAA);
    wr_reg(bus_rdata & 8'h7F);
    rd_reg("R10 bit-clear rmw");

    wr_reg(8'h20);                        // R6: bit0 = 0, no clear
    rd_reg("R6 zero ack no effect");
    wr_reg(8'h21);                        // R6: acknowledge
    rd_reg("R6 ack clears");
    #1 chk("R6 flags cleared", bus_rdata, 8'h20);

    wr_reg(8'hA0);
    step("R7 collide", 8'h1F, 0, 1, 8'hA1, 1, 0, 0, 0);
    rd_reg("R7 set wins");
    #1 chk("R7 pin flag kept", bus_rdata, 8'hA8);
    step("R7 collide port", 8'h1F, 0, 1, 8'hA1, 0, 1, 0, 0);
    rd_reg("R7 port wins");
    #1 chk("R7 port flag only", bus_rdata, 8'hA2);

    step("R9 wait", 8'h1F, 0, 1, 8'h01, 0, 0, 0, 1);
    rd_reg("R9 wait forces en");
    #1 chk("R9 wait value", bus_rdata, 8'h80);
    wr_reg(8'h00);
    rd_reg("R9 en cleared");
    step("R9 stop", 8'h00, 0, 0, 8'h00, 0, 0, 1, 0);
    rd_reg("R9 stop forces en");
    #1 chk("R9 stop value", bus_rdata, 8'h80);

    rd_reg("R2 ack reads zero");
    #1 chk("R2 bit0 zero", bus_rdata & 8'h55, 8'h00);
    repeat (2) rd_reg("R8 settle");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule